// File: doc/BRIEF.md
# Singly-Linked Sharing List Directory Controller

This block is the memory side of a distributed coherence directory in which every memory line stores a single data word and a pointer to the first cache of its sharing list. Each cache on the list keeps its own successor pointer. The controller never sees those successor pointers except when a writer quotes its own. Caches send it read requests, write-through requests and replacement invalidates. It answers each accepted packet with exactly one outgoing packet one clock later. The outgoing packet is a read reply, a write grant, an invalidate acknowledge, or an invalidate sent to the current list head. The invalidate starts a walk down the list. That walk is done by the caches and lies outside this block.

A read makes the requester the new list head. The reply carries the previous head, or the tail marker when the line had no sharers, and the requester adopts that value as its successor. A write is granted at once only when the writer shows it is the sole member of the list. When it is not, memory still takes the data and makes the writer the head. It then sends an invalidate naming the writer to the old head, and the last cache on the walk acknowledges directly to the writer. A replacement invalidate empties the line's list. Memory either acknowledges at once, or hands the walk to the head.

Top module: `dir_sll_ctrl`

## Requirements
- R1: After reset out_valid_o is 0 and every line is uncached with data 0, so a first read of any line returns data 0 and pointer 7.
- R2: An accepted read request (type 0) on an uncached line yields, one cycle later, a reply of type 1 to the requester. The reply carries the line data and pointer 7, the tail marker, and the requester becomes the head.
- R3: An accepted read request on a cached line yields a type 1 reply to the requester with the line data. Its pointer field is the previous head, and the requester becomes the head.
- R4: A write request (type 4) whose pointer field is 7 from the cache that is the current head yields a type 5 grant to the writer with pointer 7. The line data becomes the write data.
- R5: A write request on a cached line that fails the R4 check yields an invalidate (type 2) sent to the previous head, with the pointer field equal to the writer. The line data is updated and the writer becomes the head.
- R6: A write request on an uncached line yields a type 5 grant to the writer, stores the data and makes the writer the head.
- R7: A replacement invalidate (type 2) from the head, or on an uncached line, yields an acknowledge (type 3) to the requester. The line becomes uncached.
- R8: A replacement invalidate from a cache that is not the head yields an invalidate to the head, with the pointer field equal to the requester. The line becomes uncached.
- R9: A packet whose destination is not 4 (the memory node), or whose type is not 0, 2 or 4, produces no output and changes no line.
- R10: Each accepted packet yields exactly one output packet in the next cycle. Its source field is 4 and its address echoes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Incoming packet present |
| in_type_i | input | 3 | Incoming packet type |
| in_src_i | input | 3 | Sending cache number |
| in_dst_i | input | 3 | Destination node; memory is 4 |
| in_addr_i | input | 4 | Line address |
| in_data_i | input | 16 | Write data |
| in_ptr_i | input | 3 | Writer's successor pointer |
| out_valid_o | output | 1 | Outgoing packet present |
| out_type_o | output | 3 | Outgoing packet type |
| out_src_o | output | 3 | Source node, always 4 |
| out_dst_o | output | 3 | Destination cache |
| out_addr_o | output | 4 | Line address |
| out_data_o | output | 16 | Line data or written data |
| out_ptr_o | output | 3 | Old head, tail marker or new-head identity |

## Verification
On every cycle, the assertions check the packet framing. An accepted request produces exactly one reply one cycle later, and anything else produces nothing. Read replies, grants and acknowledges go back to the requester, and forwarded invalidates always name the requester. Whether the head pointer and data actually evolve correctly can only be shown by the bench's scenarios. These include the old head returned on a second read, the grant or refusal of a write, and a line that becomes uncached after replacement. Each of these is observed through later reads of the same line.

// File: rtl/dir_sll_pkg.sv
package dir_sll_pkg;
  localparam int TW = 3;
  localparam logic [TW-1:0] PK_RR = 3'd0;
  localparam logic [TW-1:0] PK_RA = 3'd1;
  localparam logic [TW-1:0] PK_IV = 3'd2;
  localparam logic [TW-1:0] PK_IA = 3'd3;
  localparam logic [TW-1:0] PK_WR = 3'd4;
  localparam logic [TW-1:0] PK_WA = 3'd5;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NLINES = 16,
  parameter int DW = 16,
  parameter int PW = 3,
  parameter logic [PW-1:0] NONE = '1,
  localparam int AW = $clog2(NLINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [PW-1:0] rd_head_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_data_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_head_en_i,
  input  logic [PW-1:0] wr_head_i
);
  logic [DW-1:0] data_q [NLINES];
  logic [PW-1:0] head_q [NLINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NLINES; i++) begin
        data_q[i] <= '0;
        head_q[i] <= NONE;
      end
    end else begin
      if (wr_data_en_i) data_q[wr_addr_i] <= wr_data_i;
      if (wr_head_en_i) head_q[wr_addr_i] <= wr_head_i;
    end
  end

  assign rd_data_o = data_q[rd_addr_i];
  assign rd_head_o = head_q[rd_addr_i];
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_sll_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3,
  parameter logic [PW-1:0] MEM_ID = '0,
  parameter logic [PW-1:0] NONE = '1,
  parameter logic [PW-1:0] TAIL = '1
) (
  input  logic          valid_i,
  input  logic [TW-1:0] type_i,
  input  logic [PW-1:0] src_i,
  input  logic [PW-1:0] dst_i,
  input  logic [DW-1:0] data_i,
  input  logic [PW-1:0] ptr_i,
  input  logic [DW-1:0] cur_data_i,
  input  logic [PW-1:0] cur_head_i,
  output logic          accept_o,
  output logic          data_en_o,
  output logic          head_en_o,
  output logic [PW-1:0] new_head_o,
  output logic [TW-1:0] o_type_o,
  output logic [PW-1:0] o_dst_o,
  output logic [DW-1:0] o_data_o,
  output logic [PW-1:0] o_ptr_o
);
  logic cached;
  logic sole_owner;
  logic known_type;

  assign cached     = cur_head_i != NONE;
  assign sole_owner = (ptr_i == TAIL) && (cur_head_i == src_i);
  assign known_type = (type_i == PK_RR) || (type_i == PK_WR) || (type_i == PK_IV);
  assign accept_o   = valid_i && (dst_i == MEM_ID) && known_type;

  always_comb begin
    data_en_o  = 1'b0;
    head_en_o  = 1'b0;
    new_head_o = src_i;
    o_type_o   = PK_RA;
    o_dst_o    = src_i;
    o_data_o   = cur_data_i;
    o_ptr_o    = TAIL;
    if (accept_o) begin
      unique case (type_i)
        PK_RR: begin
          head_en_o = 1'b1;
          o_ptr_o   = cached ? cur_head_i : TAIL;
        end
        PK_WR: begin
          data_en_o = 1'b1;
          head_en_o = 1'b1;
          o_data_o  = data_i;
          if (!cached || sole_owner) begin
            o_type_o = PK_WA;
          end else begin
            // forward walk to old head, naming writer as new head
            o_type_o = PK_IV;
            o_dst_o  = cur_head_i;
            o_ptr_o  = src_i;
          end
        end
        default: begin
          head_en_o  = 1'b1;
          new_head_o = NONE;
          if (!cached || cur_head_i == src_i) begin
            o_type_o = PK_IA;
          end else begin
            o_type_o = PK_IV;
            o_dst_o  = cur_head_i;
            o_ptr_o  = src_i;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dir_sll_ctrl.sv
module dir_sll_ctrl
  import dir_sll_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NLINES = 16,
  parameter int DW = 16,
  localparam int PW = $clog2(NCACHE + 3),
  localparam int AW = $clog2(NLINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [TW-1:0] in_type_i,
  input  logic [PW-1:0] in_src_i,
  input  logic [PW-1:0] in_dst_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [PW-1:0] in_ptr_i,
  output logic          out_valid_o,
  output logic [TW-1:0] out_type_o,
  output logic [PW-1:0] out_src_o,
  output logic [PW-1:0] out_dst_o,
  output logic [AW-1:0] out_addr_o,
  output logic [DW-1:0] out_data_o,
  output logic [PW-1:0] out_ptr_o
);
  localparam logic [PW-1:0] MEM_ID = PW'(NCACHE);
  localparam logic [PW-1:0] TAIL   = '1;
  localparam logic [PW-1:0] NONE   = TAIL - PW'(1);

  logic [DW-1:0] cur_data;
  logic [PW-1:0] cur_head;
  logic          accept, data_en, head_en;
  logic [PW-1:0] new_head, d_dst, d_ptr;
  logic [TW-1:0] d_type;
  logic [DW-1:0] d_data;

  dir_store #(.NLINES(NLINES), .DW(DW), .PW(PW), .NONE(NONE)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_addr_i    (in_addr_i),
    .rd_data_o    (cur_data),
    .rd_head_o    (cur_head),
    .wr_addr_i    (in_addr_i),
    .wr_data_en_i (data_en),
    .wr_data_i    (in_data_i),
    .wr_head_en_i (head_en),
    .wr_head_i    (new_head)
  );

  dir_decide #(.DW(DW), .PW(PW), .MEM_ID(MEM_ID), .NONE(NONE), .TAIL(TAIL)) u_decide (
    .valid_i    (in_valid_i),
    .type_i     (in_type_i),
    .src_i      (in_src_i),
    .dst_i      (in_dst_i),
    .data_i     (in_data_i),
    .ptr_i      (in_ptr_i),
    .cur_data_i (cur_data),
    .cur_head_i (cur_head),
    .accept_o   (accept),
    .data_en_o  (data_en),
    .head_en_o  (head_en),
    .new_head_o (new_head),
    .o_type_o   (d_type),
    .o_dst_o    (d_dst),
    .o_data_o   (d_data),
    .o_ptr_o    (d_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_type_o  <= PK_RA;
      out_dst_o   <= '0;
      out_addr_o  <= '0;
      out_data_o  <= '0;
      out_ptr_o   <= TAIL;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        out_type_o <= d_type;
        out_dst_o  <= d_dst;
        out_addr_o <= in_addr_i;
        out_data_o <= d_data;
        out_ptr_o  <= d_ptr;
      end
    end
  end

  assign out_src_o = MEM_ID;
endmodule

// File: rtl/dir_sll_chk.sv
module dir_sll_chk
  import dir_sll_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [TW-1:0] in_type_i,
  input logic [PW-1:0] in_src_i,
  input logic [PW-1:0] in_dst_i,
  input logic          out_valid_o,
  input logic [TW-1:0] out_type_o,
  input logic [PW-1:0] out_src_o,
  input logic [PW-1:0] out_dst_o,
  input logic [PW-1:0] out_ptr_o
);
  localparam logic [PW-1:0] MEM_ID = PW'(NCACHE);
  logic req_ok;
  assign req_ok = in_valid_i && (in_dst_i == MEM_ID) &&
                  ((in_type_i == PK_RR) || (in_type_i == PK_WR) || (in_type_i == PK_IV));

  // R10
  one_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> out_valid_o);
  // R9
  no_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ok |=> !out_valid_o);
  // R10
  src_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_src_o == MEM_ID);
  // R2
  ra_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok ##1 (out_type_o == PK_RA) |-> out_dst_o == $past(in_src_i) && $past(in_type_i) == PK_RR);
  // R4
  wa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok ##1 (out_type_o == PK_WA) |-> $past(in_type_i) == PK_WR && out_dst_o == $past(in_src_i));
  // R5
  iv_name_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok ##1 (out_type_o == PK_IV) |-> out_ptr_o == $past(in_src_i) && $past(in_type_i) != PK_RR);
  // R7
  ia_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok ##1 (out_type_o == PK_IA) |-> $past(in_type_i) == PK_IV && out_dst_o == $past(in_src_i));
endmodule

bind dir_sll_ctrl dir_sll_chk #(.NCACHE(NCACHE), .PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_type_i   (in_type_i),
  .in_src_i    (in_src_i),
  .in_dst_i    (in_dst_i),
  .out_valid_o (out_valid_o),
  .out_type_o  (out_type_o),
  .out_src_o   (out_src_o),
  .out_dst_o   (out_dst_o),
  .out_ptr_o   (out_ptr_o)
);

// File: tb/tb_dir_sll_ctrl.sv
module tb_dir_sll_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_type = '0, in_src = '0, in_dst = '0, in_ptr = '0;
  logic [3:0] in_addr = '0;
  logic [15:0] in_data = '0;
  logic       out_valid;
  logic [2:0] out_type, out_src, out_dst, out_ptr;
  logic [3:0] out_addr;
  logic [15:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_head [NL];
  logic [15:0] m_data [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_sll_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_type_i(in_type), .in_src_i(in_src), .in_dst_i(in_dst),
    .in_addr_i(in_addr), .in_data_i(in_data), .in_ptr_i(in_ptr),
    .out_valid_o(out_valid), .out_type_o(out_type), .out_src_o(out_src), .out_dst_o(out_dst),
    .out_addr_o(out_addr), .out_data_o(out_data), .out_ptr_o(out_ptr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model: head -1 means uncached
  task automatic send(int t, int s, int d, int a, int dat, int p);
    bit ev; int et, edst, eptr; logic [15:0] edat; string tag;
    ev = (d == 4) && (t == 0 || t == 2 || t == 4);
    et = 0; edst = s; eptr = 7; edat = m_data[a]; tag = "R9";
    if (ev) begin
      if (t == 0) begin
        tag = (m_head[a] < 0) ? "R2" : "R3";
        et = 1; eptr = (m_head[a] < 0) ? 7 : m_head[a];
        m_head[a] = s;
      end else if (t == 4) begin
        edat = dat[15:0];
        if (m_head[a] < 0 || (p == 7 && m_head[a] == s)) begin
          tag = (m_head[a] < 0) ? "R6" : "R4"; et = 5;
        end else begin
          tag = "R5"; et = 2; edst = m_head[a]; eptr = s;
        end
        m_data[a] = dat[15:0]; m_head[a] = s;
      end else begin
        if (m_head[a] < 0 || m_head[a] == s) begin
          tag = "R7"; et = 3;
        end else begin
          tag = "R8"; et = 2; edst = m_head[a]; eptr = s;
        end
        m_head[a] = -1;
      end
    end
    @(negedge clk);
    in_valid = 1; in_type = t[2:0]; in_src = s[2:0]; in_dst = d[2:0];
    in_addr = a[3:0]; in_data = dat[15:0]; in_ptr = p[2:0];
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, {31'b0, out_valid}, {31'b0, ev});
    if (ev) begin
      chk({tag, " type"}, {29'b0, out_type}, et);
      chk({tag, " dst"}, {29'b0, out_dst}, edst);
      chk({tag, " ptr"}, {29'b0, out_ptr}, eptr);
      chk({tag, " data"}, {16'b0, out_data}, {16'b0, edat});
      chk("R10 src", {29'b0, out_src}, 4);
      chk("R10 addr", {28'b0, out_addr}, a);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_head[i] = -1; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, out_valid}, 0);
    rst_n = 1;
    // directed corner cases on line 5
    send(0, 1, 4, 5, 0, 0);       // R1 R2 first read: data 0, tail
    send(0, 2, 4, 5, 0, 0);       // R3 old head 1
    send(4, 1, 4, 5, 16'h1234, 7);// R5 head is 2
    send(4, 1, 4, 5, 16'haaaa, 7);// R4 sole owner
    send(4, 1, 4, 5, 16'hbbbb, 2);// R5 head but not tail
    send(2, 3, 4, 5, 0, 0);       // R8 non-head replacement
    send(4, 0, 4, 5, 16'h0c0c, 2);// R6 uncached write
    send(2, 0, 4, 5, 0, 0);       // R7 head replacement
    send(2, 2, 4, 5, 0, 0);       // R7 uncached replacement
    send(0, 2, 2, 5, 0, 0);       // R9 wrong destination
    send(6, 2, 4, 5, 0, 0);       // R9 unknown type
    send(1, 2, 4, 5, 0, 0);       // R9 reply type inbound
    send(0, 3, 4, 5, 0, 0);       // R7 line uncached, data kept
    send(0, 0, 4, 9, 0, 0);       // R1 untouched line
    for (int n = 0; n < 400; n++) begin
      int t, s, d, a, p, r;
      r = $urandom_range(0, 9);
      t = (r < 3) ? 0 : (r < 6) ? 4 : (r < 8) ? 2 : $urandom_range(0, 7);
      s = $urandom_range(0, 3);
      d = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : 4;
      a = $urandom_range(0, 3);
      p = ($urandom_range(0, 1) == 0) ? 7 : $urandom_range(0, 3);
      send(t, s, d, a, $urandom_range(0, 65535), p);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1957);
  end
endmodule